// File: doc/BRIEF.md
# Fused Shift-and-Arithmetic Execute Unit

This block is the combinational execute stage of a 16-bit single-cycle processor. It handles the data instructions and leaves branches to other logic. An operation select picks one of six fused operations:

- a store whose address is the sum of two registers and whose data is a scaled register plus a small immediate;
- a compare that produces an all-ones or all-zeros mask;
- a load whose returned word is multiplied by a power of four;
- an upper-byte immediate built from a shifted, sign-extended constant;
- a shifted subtract whose borrow flag follows a signed or unsigned mode bit;
- a byte merge / invert.

The register values, immediate, shift amount, mode bit and memory read word come in from the decode and memory stages. The write-back value, memory address, store data and strobes go back out. The block holds no state. Every output settles in the same cycle as its inputs. Any output that the selected operation does not use is driven to zero.

Top module: `exu_shift_unit`

## Requirements
- R1: With opSel=3'b000 (store), memAddr = (rsVal+rtVal) mod 2^16, memWdata = (16*rdVal + immVal[3:0]) mod 2^16, memWe=1, wbEn=0 and wbData=0.
- R2: With opSel=3'b001 (compare), wbEn=1 and wbData is 16'hFFFF when rsVal equals the 8-bit immVal sign-extended to 16 bits, otherwise 16'h0000.
- R3: With opSel=3'b010 (load), memAddr is the 12-bit value {immVal, 4'b0000} sign-extended to 16 bits, and memWe=0.
- R4: With opSel=3'b010 (load), wbEn=1 and wbData = memRdata shifted left by 2*shamt and truncated to 16 bits, so shamt of 8 or more yields zero.
- R5: With opSel=3'b011 (upper), wbEn=1, wbData[15:8] = bits [15:8] of (sign-extended immVal << shamt) and wbData[7:0] = 8'h00.
- R6: With opSel=3'b100 (subtract), wbEn=1 and wbData = ((rsVal - rtVal) << shamt) truncated to 16 bits, the same for either value of qBit.
- R7: With opSel=3'b100, borrowFlag is the signed overflow of rsVal-rtVal when qBit=1 and the unsigned borrow (rsVal < rtVal) when qBit=0; borrowFlag is 0 for every other opSel.
- R8: With opSel=3'b101 (merge), wbEn=1 and wbData = {rsVal[15:8], rtVal[7:0]} when qBit=1, or ~rsVal when qBit=0.
- R9: opSel 3'b110 and 3'b111 are idle: all outputs are zero. Under every opSel, outputs that the operation does not name (memAddr and memWdata outside store/load, memWe outside store, wbData outside write-back operations) are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opSel | input | 3 | Operation select (encoding in R1-R9) |
| qBit | input | 1 | Mode bit for subtract and merge |
| rdVal | input | 16 | Destination register value (store scaling) |
| rsVal | input | 16 | First source register value |
| rtVal | input | 16 | Second source register value |
| immVal | input | 8 | Immediate field |
| shamt | input | 4 | Shift amount |
| memRdata | input | 16 | Memory read word for loads |
| wbData | output | 16 | Register write-back value |
| wbEn | output | 1 | Write-back enable |
| memAddr | output | 16 | Memory address |
| memWdata | output | 16 | Store data |
| memWe | output | 1 | Memory write enable |
| borrowFlag | output | 1 | Subtract borrow or overflow |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between the inputs and the outputs. The driver applies inputs 2 ns after a rising edge and queues the expected item. The monitor pops that item and compares it at the following falling edge, which is one half period later and well after the combinational outputs have settled. Each item is compared exactly once, before the next stimulus arrives.

// File: rtl/exu_shift_pkg.sv
package exu_shift_pkg;

  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_STORE = 3'b000,
    OP_CMP   = 3'b001,
    OP_LOAD  = 3'b010,
    OP_UPPER = 3'b011,
    OP_SUB   = 3'b100,
    OP_MERGE = 3'b101,
    OP_IDLE6 = 3'b110,
    OP_IDLE7 = 3'b111
  } exuOp_e;

  typedef enum logic [2:0] {
    WB_NONE  = 3'd0,
    WB_MASK  = 3'd1,
    WB_LOAD  = 3'd2,
    WB_UPPER = 3'd3,
    WB_SUB   = 3'd4,
    WB_MERGE = 3'd5
  } wbSel_e;

  typedef enum logic [1:0] {
    AD_NONE  = 2'd0,
    AD_STORE = 2'd1,
    AD_LOAD  = 2'd2
  } addrSel_e;

  typedef struct packed {
    wbSel_e   wbSel;
    addrSel_e addrSel;
    logic     wbEn;
    logic     memWe;
    logic     flagEn;
    logic     modeQ;
  } exuStrobe_t;

endpackage

// File: rtl/exu_shift_ctrl.sv
module exu_shift_ctrl
  import exu_shift_pkg::*;
(
  input  logic [OP_W-1:0] opSel,
  input  logic            qBit,
  output exuStrobe_t      strobe
);

  always_comb begin
    strobe = '{wbSel: WB_NONE, addrSel: AD_NONE, wbEn: 1'b0,
               memWe: 1'b0, flagEn: 1'b0, modeQ: qBit};
    unique case (exuOp_e'(opSel))
      OP_STORE: begin
        strobe.addrSel = AD_STORE;
        strobe.memWe   = 1'b1;
      end
      OP_CMP: begin
        strobe.wbSel = WB_MASK;
        strobe.wbEn  = 1'b1;
      end
      OP_LOAD: begin
        strobe.wbSel   = WB_LOAD;
        strobe.addrSel = AD_LOAD;
        strobe.wbEn    = 1'b1;
      end
      OP_UPPER: begin
        strobe.wbSel = WB_UPPER;
        strobe.wbEn  = 1'b1;
      end
      OP_SUB: begin
        strobe.wbSel  = WB_SUB;
        strobe.wbEn   = 1'b1;
        strobe.flagEn = 1'b1;
      end
      OP_MERGE: begin
        strobe.wbSel = WB_MERGE;
        strobe.wbEn  = 1'b1;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/exu_shift_datapath.sv
module exu_shift_datapath
  import exu_shift_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int IMM_W   = 8,
  parameter int SIMM_W  = 4,
  parameter int SHAMT_W = 4
) (
  input  exuStrobe_t         strobe,
  input  logic [DATA_W-1:0]  rdVal,
  input  logic [DATA_W-1:0]  rsVal,
  input  logic [DATA_W-1:0]  rtVal,
  input  logic [IMM_W-1:0]   immVal,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [DATA_W-1:0]  memRdata,
  output logic [DATA_W-1:0]  wbData,
  output logic               wbEn,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic               memWe,
  output logic               borrowFlag
);

  localparam int LD_LOW_W = 4;
  localparam int LD_PAD_W = DATA_W - IMM_W - LD_LOW_W;
  localparam int SX_PAD_W = DATA_W - IMM_W;
  localparam int HALF_W   = DATA_W / 2;
  localparam int MSB      = DATA_W - 1;

  logic [DATA_W-1:0]  immSext;
  logic [DATA_W-1:0]  immStoreZext;
  logic [DATA_W-1:0]  loadAddr;
  logic [DATA_W-1:0]  storeAddr;
  logic [DATA_W-1:0]  storeData;
  logic [SHAMT_W:0]   loadShift;
  logic [DATA_W-1:0]  loadRes;
  logic [DATA_W-1:0]  upperFull;
  logic [DATA_W-1:0]  upperRes;
  logic [DATA_W-1:0]  diff;
  logic [DATA_W-1:0]  subRes;
  logic               unsBorrow;
  logic               sgnOvf;
  logic [DATA_W-1:0]  mergeRes;
  logic [DATA_W-1:0]  maskRes;

  // immediate forms
  assign immSext      = {{SX_PAD_W{immVal[IMM_W-1]}}, immVal};
  assign immStoreZext = {{(DATA_W-SIMM_W){1'b0}}, immVal[SIMM_W-1:0]};
  assign loadAddr     = {{LD_PAD_W{immVal[IMM_W-1]}}, immVal, {LD_LOW_W{1'b0}}};

  // store path
  assign storeAddr = rsVal + rtVal;
  assign storeData = (rdVal << LD_LOW_W) + immStoreZext;

  // load path: multiply by 4^shamt
  assign loadShift = {shamt, 1'b0};
  assign loadRes   = memRdata << loadShift;

  // upper-byte immediate
  assign upperFull = immSext << shamt;
  assign upperRes  = {upperFull[MSB:HALF_W], {HALF_W{1'b0}}};

  // compare mask
  assign maskRes = (rsVal == immSext) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};

  // subtract with mode-dependent flag
  assign diff      = rsVal - rtVal;
  assign subRes    = diff << shamt;
  assign unsBorrow = rsVal < rtVal;
  assign sgnOvf    = (rsVal[MSB] != rtVal[MSB]) && (diff[MSB] != rsVal[MSB]);

  // merge / invert
  assign mergeRes = strobe.modeQ ? {rsVal[MSB:HALF_W], rtVal[HALF_W-1:0]} : ~rsVal;

  always_comb begin
    unique case (strobe.wbSel)
      WB_MASK:  wbData = maskRes;
      WB_LOAD:  wbData = loadRes;
      WB_UPPER: wbData = upperRes;
      WB_SUB:   wbData = subRes;
      WB_MERGE: wbData = mergeRes;
      default:  wbData = '0;
    endcase
  end

  always_comb begin
    unique case (strobe.addrSel)
      AD_STORE: memAddr = storeAddr;
      AD_LOAD:  memAddr = loadAddr;
      default:  memAddr = '0;
    endcase
  end

  assign memWdata   = strobe.memWe ? storeData : '0;
  assign memWe      = strobe.memWe;
  assign wbEn       = strobe.wbEn;
  assign borrowFlag = strobe.flagEn & (strobe.modeQ ? sgnOvf : unsBorrow);

endmodule

// File: rtl/exu_shift_unit.sv
module exu_shift_unit
  import exu_shift_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int IMM_W   = 8,
  parameter int SIMM_W  = 4,
  parameter int SHAMT_W = 4
) (
  input  logic [OP_W-1:0]    opSel,
  input  logic               qBit,
  input  logic [DATA_W-1:0]  rdVal,
  input  logic [DATA_W-1:0]  rsVal,
  input  logic [DATA_W-1:0]  rtVal,
  input  logic [IMM_W-1:0]   immVal,
  input  logic [SHAMT_W-1:0] shamt,
  input  logic [DATA_W-1:0]  memRdata,
  output logic [DATA_W-1:0]  wbData,
  output logic               wbEn,
  output logic [DATA_W-1:0]  memAddr,
  output logic [DATA_W-1:0]  memWdata,
  output logic               memWe,
  output logic               borrowFlag
);

  exuStrobe_t strobe;

  exu_shift_ctrl ctrl_i (
    .opSel  (opSel),
    .qBit   (qBit),
    .strobe (strobe)
  );

  exu_shift_datapath #(
    .DATA_W  (DATA_W),
    .IMM_W   (IMM_W),
    .SIMM_W  (SIMM_W),
    .SHAMT_W (SHAMT_W)
  ) dp_i (
    .strobe     (strobe),
    .rdVal      (rdVal),
    .rsVal      (rsVal),
    .rtVal      (rtVal),
    .immVal     (immVal),
    .shamt      (shamt),
    .memRdata   (memRdata),
    .wbData     (wbData),
    .wbEn       (wbEn),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memWe      (memWe),
    .borrowFlag (borrowFlag)
  );

endmodule

// File: rtl/exu_shift_unit_chk.sv
module exu_shift_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic [2:0]        opSel,
  input logic [DATA_W-1:0] wbData,
  input logic              wbEn,
  input logic [DATA_W-1:0] memAddr,
  input logic [DATA_W-1:0] memWdata,
  input logic              memWe,
  input logic              borrowFlag
);

  always_comb begin
    if (!$isunknown(opSel)) begin
      // R9: idle codes leave every output at zero
      p_idle_quiet_r9: assert (opSel < 3'b110 ||
        (wbData == '0 && !wbEn && memAddr == '0 && memWdata == '0 && !memWe && !borrowFlag))
        else $error("idle opSel drives a nonzero output");
      // R1: only a store writes memory
      p_store_only_we_r1: assert (memWe == (opSel == 3'b000))
        else $error("memWe does not follow the store code");
      // R2: compare result is a full mask
      p_cmp_mask_r2: assert (opSel != 3'b001 || wbData == '0 || wbData == '1)
        else $error("compare result is not a mask");
      // R5: upper result has a clear low byte
      p_upper_low_zero_r5: assert (opSel != 3'b011 || wbData[DATA_W/2-1:0] == '0)
        else $error("upper result low byte nonzero");
      // R7: borrow flag only under subtract
      p_flag_only_sub_r7: assert (!borrowFlag || opSel == 3'b100)
        else $error("borrowFlag raised outside subtract");
      // R9: store writes nothing back
      p_store_no_wb_r9: assert (opSel != 3'b000 || (!wbEn && wbData == '0))
        else $error("store drives write-back");
    end
  end

endmodule

bind exu_shift_unit exu_shift_unit_chk #(.DATA_W(DATA_W)) chk_i (.*);

// File: tb/exu_shift_unit_tb_top.sv
module exu_shift_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  opSel;
  logic        qBit;
  logic [15:0] rdVal, rsVal, rtVal, memRdata;
  logic [7:0]  immVal;
  logic [3:0]  shamt;
  logic [15:0] wbData, memAddr, memWdata;
  logic        wbEn, memWe, borrowFlag;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #10 clk = ~clk;  // 50 MHz

  exu_shift_unit dut_i (
    .opSel(opSel), .qBit(qBit), .rdVal(rdVal), .rsVal(rsVal), .rtVal(rtVal),
    .immVal(immVal), .shamt(shamt), .memRdata(memRdata),
    .wbData(wbData), .wbEn(wbEn), .memAddr(memAddr), .memWdata(memWdata),
    .memWe(memWe), .borrowFlag(borrowFlag)
  );

  typedef struct {
    string       req;
    logic [15:0] wb;
    logic        en;
    logic [15:0] addr;
    logic [15:0] wdat;
    logic        we;
    logic        flag;
  } expItem_t;

  expItem_t sbQueue[$];

  function automatic expItem_t model(input logic [2:0] op, input logic q,
      input logic [15:0] rd, input logic [15:0] rs, input logic [15:0] rt,
      input logic [7:0] imm, input logic [3:0] sh, input logic [15:0] mrd, input string req);
    expItem_t e;
    logic [15:0] sx;
    logic [31:0] wide;
    logic signed [16:0] sdiff;
    e.req = req; e.wb = '0; e.en = 0; e.addr = '0; e.wdat = '0; e.we = 0; e.flag = 0;
    sx = {{8{imm[7]}}, imm};
    case (op)
      3'b000: begin
        e.addr = 16'((32'(rs) + 32'(rt)) % 32'h10000);
        e.wdat = 16'((32'(rd) * 16 + 32'(imm[3:0])) % 32'h10000);
        e.we = 1;
      end
      3'b001: begin e.en = 1; e.wb = (rs == sx) ? 16'hFFFF : 16'h0000; end
      3'b010: begin
        e.en = 1;
        e.addr = {{4{imm[7]}}, imm, 4'h0};
        wide = 32'(mrd);
        for (int i = 0; i < int'(sh); i++) wide = wide * 4;
        e.wb = (sh >= 4'd8) ? 16'h0 : wide[15:0];
      end
      3'b011: begin
        e.en = 1;
        wide = 32'(sx) * (32'd1 << sh);
        e.wb = {wide[15:8], 8'h00};
      end
      3'b100: begin
        e.en = 1;
        wide = (32'(rs) + 32'h10000 - 32'(rt)) * (32'd1 << sh);
        e.wb = wide[15:0];
        sdiff = $signed({rs[15], rs}) - $signed({rt[15], rt});
        e.flag = q ? (sdiff > 17'sd32767 || sdiff < -17'sd32768) : (rs < rt);
      end
      3'b101: begin e.en = 1; e.wb = q ? {rs[15:8], rt[7:0]} : ~rs; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic [2:0] op, input logic q, input logic [15:0] rd,
      input logic [15:0] rs, input logic [15:0] rt, input logic [7:0] imm,
      input logic [3:0] sh, input logic [15:0] mrd, input string req);
    @(posedge clk);
    #2;
    opSel = op; qBit = q; rdVal = rd; rsVal = rs; rtVal = rt;
    immVal = imm; shamt = sh; memRdata = mrd;
    sbQueue.push_back(model(op, q, rd, rs, rt, imm, sh, mrd, req));
  endtask

  task automatic checkOne(input string req, input string what, input logic [15:0] act,
                          input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // monitor: results are combinational, compared half a period after drive
  always @(negedge clk) begin
    if (sbQueue.size() > 0) begin
      expItem_t e;
      e = sbQueue.pop_front();
      checkOne(e.req, "wbData",   wbData,   e.wb);
      checkOne(e.req, "wbEn",     16'(wbEn), 16'(e.en));
      checkOne(e.req, "memAddr",  memAddr,  e.addr);
      checkOne(e.req, "memWdata", memWdata, e.wdat);
      checkOne(e.req, "memWe",    16'(memWe), 16'(e.we));
      checkOne(e.req, "borrowFlag", 16'(borrowFlag), 16'(e.flag));
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    opSel = 3'b111; qBit = 0; rdVal = 0; rsVal = 0; rtVal = 0;
    immVal = 0; shamt = 0; memRdata = 0;
    repeat (3) @(posedge clk);
    rst = 0;
    // reset state, idle code (R9)
    drive(3'b111, 0, 0, 0, 0, 0, 0, 0, "R9");
    // R1 store, including wraparound
    drive(3'b000, 0, 16'h0123, 16'h0010, 16'h0020, 8'hA7, 0, 0, "R1");
    drive(3'b000, 1, 16'hFFFF, 16'hFFFF, 16'h0002, 8'h0F, 3, 16'h1234, "R1");
    // R2 compare equal with negative immediate, and unequal
    drive(3'b001, 0, 0, 16'hFF80, 0, 8'h80, 0, 0, "R2");
    drive(3'b001, 0, 0, 16'h0080, 0, 8'h80, 0, 0, "R2");
    drive(3'b001, 1, 0, 16'h007F, 0, 8'h7F, 5, 0, "R2");
    // R3 / R4 load address and power-of-four shifts
    drive(3'b010, 0, 0, 0, 0, 8'h9C, 0, 16'hBEEF, "R3");
    drive(3'b010, 0, 0, 0, 0, 8'h12, 3, 16'h00F3, "R4");
    drive(3'b010, 0, 0, 0, 0, 8'hFF, 7, 16'h0003, "R4");
    drive(3'b010, 0, 0, 0, 0, 8'h01, 8, 16'hFFFF, "R4");
    drive(3'b010, 1, 0, 0, 0, 8'h40, 15, 16'h0001, "R4");
    // R5 upper byte
    drive(3'b011, 0, 0, 0, 0, 8'h81, 4, 0, "R5");
    drive(3'b011, 0, 0, 0, 0, 8'h7F, 0, 0, "R5");
    drive(3'b011, 0, 0, 0, 0, 8'h35, 12, 0, "R5");
    // R6 / R7 subtract in both modes
    drive(3'b100, 1, 0, 16'h8000, 16'h0001, 0, 0, 0, "R7");
    drive(3'b100, 0, 0, 16'h8000, 16'h0001, 0, 0, 0, "R7");
    drive(3'b100, 0, 0, 16'h0001, 16'h0002, 0, 2, 0, "R7");
    drive(3'b100, 1, 0, 16'h0001, 16'h0002, 0, 2, 0, "R6");
    drive(3'b100, 1, 0, 16'h7FFF, 16'hFFFF, 0, 15, 0, "R6");
    // R8 merge / invert
    drive(3'b101, 1, 0, 16'hAB12, 16'h34CD, 0, 0, 0, "R8");
    drive(3'b101, 0, 0, 16'hAB12, 16'h34CD, 0, 0, 0, "R8");
    // R9 idle codes with busy inputs
    drive(3'b110, 1, 16'hFFFF, 16'h1234, 16'h5678, 8'hFF, 15, 16'hFFFF, "R9");
    drive(3'b111, 1, 16'hFFFF, 16'hFFFF, 16'h0001, 8'h80, 7, 16'hFFFF, "R9");
    // random sweep over every code
    for (int i = 0; i < 400; i++) begin
      logic [2:0] op;
      op = 3'($urandom_range(0, 7));
      drive(op, 1'($urandom), 16'($urandom), 16'($urandom), 16'($urandom),
            8'($urandom), 4'($urandom), 16'($urandom),
            (op == 3'b100) ? "R7" : (op == 3'b101) ? "R8" : (op == 3'b010) ? "R4" : "R9");
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule